// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a 32-bit digital input port and watches the low 16 lines for interrupt conditions. Software reaches it over a plain 32-bit register bus with a one-cycle registered read response. Five word registers are decoded: the synchronised input value, two per-channel condition masks (a "high" mask and a "low" mask), a latched event status word that clears when read, and an interrupt control word.

Two combining modes are offered. In edge mode (OR), any channel whose selected edge occurs raises an event, and the status word records the channels that saw it. In level mode (AND), an event is raised only when every channel named in either mask sits at its required level at the same time. Once it has fired, a fresh level change on one of those channels is needed before it can fire again. A single active-high interrupt request line follows the latched status while the block is enabled.

A driver typically programs the masks, writes the control word, and in its handler reads the status word. It may also briefly write the control word with enable cleared and then restore it; the masks survive this.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset the control word, both masks and the status word read 0 and `irq` is low.
- R2: A read at byte offset 0x00 returns all 32 input lines as they stood after a two-flop synchroniser.
- R3: The high mask (offset 0x04) and low mask (offset 0x08) each store bits 15:0 of the write data. Written bits 31:16 are ignored, and those bits read as 0.
- R4: The control word is at offset 0x10. Bit 0 is enable and bit 1 selects level/AND mode (1) or edge/OR mode (0). Bit 2 is a read-only pending flag that is 1 while the status word is non-zero.
- R5: In edge mode with enable set, a rising edge on channel i with high-mask bit i set, or a falling edge with low-mask bit i set, sets status bit i and raises `irq`. A channel with both bits set reacts to both edges.
- R6: Input lines 16 to 31, and channels with neither mask bit set, never cause an event.
- R7: In level mode with enable set, an event fires when every channel with exactly one mask bit set is at its required level (high mask means high, low mask means low). The status word then gets one bit for each channel named in either mask.
- R8: In level mode, after an event no further event fires until some channel named in a mask changes level. Changes on other lines do not re-arm it. A control write re-arms it.
- R9: A read at offset 0x0C returns the status word, bits 15:0, and clears it; `irq` then falls.
- R10: `irq` is level-high and stays high until the status word is read or enable is cleared. Writing the control word with enable clear drops `irq` and clears the status, but both masks are kept.
- R11: In level mode no event fires if no channel is named in either mask, or if any channel has both mask bits set.
- R12: For an input change set up before clock edge k, `irq` and the status word change after edge k+2 and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| din | input | 32 | Asynchronous digital input lines |
| irq | output | 1 | Level-high interrupt request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle, and that control writes in level mode do not coincide with a level-mode event, except where a property exempts the re-arm cycle. The bench drives each bus access as a single-strobe transaction set up at the falling clock edge. It changes `din` only between transactions, so every input change has settled through the synchroniser before the status word is read. Status reads are queued only after the bench has waited out the full input-to-interrupt latency.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_HIGH = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LOW  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h10;
  localparam int CTL_EN   = 0;
  localparam int CTL_AND  = 1;
  localparam int CTL_PEND = 2;

  typedef struct packed {
    logic and_mode;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl  = lvl_q;
  assign prev = prev_q;
endmodule

// File: rtl/cos_event.sv
module cos_event #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] prev,
  input  logic [N-1:0] m_high,
  input  logic [N-1:0] m_low,
  input  cos_pkg::ctrl_t ctrl,
  input  logic         rearm,
  output logic         fire,
  output logic [N-1:0] hit
);
  logic [N-1:0] rise, fall, or_hit, sel, ok;
  logic         all_ok, chg, armed_q, or_fire, and_fire;

  assign rise   = lvl & ~prev;
  assign fall   = ~lvl & prev;
  assign or_hit = (rise & m_high) | (fall & m_low);
  assign sel    = m_high | m_low;

  // per channel: unselected passes, single-mask channel must match,
  // double-mask channel can never match
  generate
    for (genvar i = 0; i < N; i++) begin : g_ok
      assign ok[i] = ~sel[i]
                   | (m_high[i] & ~m_low[i] &  lvl[i])
                   | (m_low[i]  & ~m_high[i] & ~lvl[i]);
    end
  endgenerate

  assign all_ok   = (&ok) & (|sel);
  assign chg      = |((rise | fall) & sel);
  assign or_fire  = ctrl.en & ~ctrl.and_mode & (|or_hit);
  assign and_fire = ctrl.en &  ctrl.and_mode & all_ok & armed_q;
  assign fire     = or_fire | and_fire;
  assign hit      = and_fire ? sel : (or_fire ? or_hit : '0);

  always_ff @(posedge clk) begin
    if (rst)           armed_q <= 1'b1;
    else if (rearm)    armed_q <= 1'b1;
    else if (and_fire) armed_q <= 1'b0;
    else if (chg)      armed_q <= 1'b1;
  end

  // R8: a level-mode event cannot repeat on the next cycle without re-arm
  assert_and_no_refire_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl.en && ctrl.and_mode && fire && !rearm) |=> !(fire && ctrl.and_mode));
endmodule

// File: rtl/cos_regs.sv
module cos_regs #(
  parameter int DW = 32,
  parameter int N  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [cos_pkg::ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]              bus_wdata,
  input  logic [DW-1:0]              raw,
  input  logic                       fire,
  input  logic [N-1:0]               hit,
  output logic [DW-1:0]              bus_rdata,
  output logic                       bus_rvalid,
  output logic [N-1:0]               m_high,
  output logic [N-1:0]               m_low,
  output cos_pkg::ctrl_t             ctrl,
  output logic                       rearm,
  output logic                       irq
);
  import cos_pkg::*;
  localparam int PAD = DW - N;

  logic [N-1:0] mh_q, ml_q, stat_q, stat_n;
  ctrl_t        ctrl_q, ctrl_n;
  logic         wr_ctrl, rd_stat, irq_q, rvalid_q;
  logic [DW-1:0] rdata_q;

  assign wr_ctrl = bus_wr && bus_addr == OFS_CTRL;
  assign rd_stat = bus_rd && bus_addr == OFS_STAT;

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_ctrl) begin
      ctrl_n.en       = bus_wdata[CTL_EN];
      ctrl_n.and_mode = bus_wdata[CTL_AND];
    end
    stat_n = (rd_stat ? '0 : stat_q) | hit;
    if (!ctrl_n.en) stat_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mh_q     <= '0;
      ml_q     <= '0;
      ctrl_q   <= '0;
      stat_q   <= '0;
      irq_q    <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_HIGH) mh_q <= bus_wdata[N-1:0];
      if (bus_wr && bus_addr == OFS_LOW)  ml_q <= bus_wdata[N-1:0];
      ctrl_q   <= ctrl_n;
      stat_q   <= stat_n;
      irq_q    <= ctrl_n.en & (|stat_n);
      rvalid_q <= bus_rd;
      if (bus_rd) begin
        unique case (bus_addr)
          OFS_RAW:  rdata_q <= raw;
          OFS_HIGH: rdata_q <= {{PAD{1'b0}}, mh_q};
          OFS_LOW:  rdata_q <= {{PAD{1'b0}}, ml_q};
          OFS_STAT: rdata_q <= {{PAD{1'b0}}, stat_q};
          OFS_CTRL: rdata_q <= {{(DW-3){1'b0}}, |stat_q,
                                ctrl_q.and_mode, ctrl_q.en};
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign m_high     = mh_q;
  assign m_low      = ml_q;
  assign ctrl       = ctrl_q;
  assign rearm      = wr_ctrl;
  assign irq        = irq_q;
  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R9: reading the status with no new event leaves it empty
  assert_stat_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !fire) |=> stat_q == '0);
  // R10: irq holds until a status read or a control write
  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !rd_stat && !wr_ctrl) |=> irq_q);
  // R10: irq is never high while disabled
  assert_irq_needs_en_R10: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ctrl_q.en);
  // R3: mask reads carry zeros above the channel field
  assert_mask_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == OFS_HIGH || bus_addr == OFS_LOW))
      |=> bus_rdata[DW-1:N] == '0);
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
  parameter int NIN  = 32,
  parameter int NIRQ = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [cos_pkg::ADDR_W-1:0] bus_addr,
  input  logic [NIN-1:0]             bus_wdata,
  output logic [NIN-1:0]             bus_rdata,
  output logic                       bus_rvalid,
  input  logic [NIN-1:0]             din,
  output logic                       irq
);
  logic [NIN-1:0]  lvl, prev;
  logic [NIRQ-1:0] m_high, m_low, hit;
  cos_pkg::ctrl_t  ctrl;
  logic            fire, rearm;

  cos_sync #(.W(NIN)) u_sync (
    .clk(clk), .rst(rst), .d(din), .lvl(lvl), .prev(prev)
  );

  cos_event #(.N(NIRQ)) u_event (
    .clk(clk), .rst(rst),
    .lvl(lvl[NIRQ-1:0]), .prev(prev[NIRQ-1:0]),
    .m_high(m_high), .m_low(m_low), .ctrl(ctrl), .rearm(rearm),
    .fire(fire), .hit(hit)
  );

  cos_regs #(.DW(NIN), .N(NIRQ)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .raw(lvl), .fire(fire), .hit(hit),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .m_high(m_high), .m_low(m_low), .ctrl(ctrl), .rearm(rearm), .irq(irq)
  );
endmodule

// File: tb/cos_irq_ctrl_tb.sv
module cos_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, din = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cos_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .din(din), .irq(irq)
  );

  // monitor: compares each read response with the queued expectation
  always @(negedge clk) begin
    if (bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read response got=%h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s read got=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq got=%b exp=%b", t, irq, e);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_din(input logic [31:0] v);
    din = v;
    cyc(3);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(5'h10, 32'h0, "R1");
    rd(5'h04, 32'h0, "R1");
    rd(5'h0C, 32'h0, "R1");
    // R2 raw inputs
    set_din(32'hA5A5_1234);
    rd(5'h00, 32'hA5A5_1234, "R2");
    set_din(32'h0);
    // R3 masks
    wr(5'h04, 32'hFFFF_0003);
    rd(5'h04, 32'h0000_0003, "R3");
    wr(5'h08, 32'h0000_0006);
    rd(5'h08, 32'h0000_0006, "R3");
    // R5 / R12 edge mode, rising on channel 0
    wr(5'h10, 32'h1);
    din = 32'h1;
    cyc(2);
    chk_irq(1'b0, "R12");
    cyc(1);
    chk_irq(1'b1, "R5");
    rd(5'h10, 32'h5, "R4");
    rd(5'h0C, 32'h1, "R5");
    chk_irq(1'b0, "R9");
    rd(5'h0C, 32'h0, "R9");
    // R6 rising on ch2 (low mask only) is ignored, falling fires
    set_din(32'h5);
    chk_irq(1'b0, "R6");
    set_din(32'h1);
    chk_irq(1'b1, "R5");
    rd(5'h0C, 32'h4, "R5");
    // ch1 in both masks: both edges
    set_din(32'h3);
    rd(5'h0C, 32'h2, "R5");
    set_din(32'h1);
    rd(5'h0C, 32'h2, "R5");
    // R6 upper lines and unmasked channel ignored
    set_din(32'h0010_0101);
    set_din(32'h0000_0001);
    chk_irq(1'b0, "R6");
    rd(5'h0C, 32'h0, "R6");
    // R10 hold and disable
    set_din(32'h0);
    set_din(32'h1);
    cyc(5);
    chk_irq(1'b1, "R10");
    wr(5'h10, 32'h0);
    chk_irq(1'b0, "R10");
    rd(5'h0C, 32'h0, "R10");
    rd(5'h04, 32'h3, "R10");
    // R7 level mode: ch0 high, ch3 low, matched at enable
    wr(5'h04, 32'h1);
    wr(5'h08, 32'h8);
    wr(5'h10, 32'h3);
    cyc(2);
    chk_irq(1'b1, "R7");
    rd(5'h0C, 32'h9, "R7");
    chk_irq(1'b0, "R8");
    cyc(4);
    chk_irq(1'b0, "R8");
    // R8 unrelated line does not re-arm
    set_din(32'h21);
    set_din(32'h01);
    cyc(2);
    chk_irq(1'b0, "R8");
    // R8 a change on ch3 re-arms
    set_din(32'h09);
    chk_irq(1'b0, "R8");
    set_din(32'h01);
    cyc(1);
    chk_irq(1'b1, "R8");
    rd(5'h0C, 32'h9, "R8");
    // R11 double-mask channel never matches
    wr(5'h10, 32'h0);
    wr(5'h04, 32'h10);
    wr(5'h08, 32'h10);
    wr(5'h10, 32'h3);
    set_din(32'h11);
    cyc(2);
    chk_irq(1'b0, "R11");
    set_din(32'h01);
    cyc(2);
    chk_irq(1'b0, "R11");
    // R11 nothing selected never fires
    wr(5'h10, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h08, 32'h0);
    wr(5'h10, 32'h3);
    cyc(4);
    chk_irq(1'b0, "R11");
    rd(5'h0C, 32'h0, "R11");
    cyc(2);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL pending reads got=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule